// File: doc/BRIEF.md
# Debug Port Protocol Select Detector

This block sits on the target side of a two-wire debug port. On every debug clock edge that the clock-enable marks, it takes one sample of the mode/data pin. From those samples it works out which protocol the port should speak: JTAG, SWD, or a low-power sleep state in which neither protocol is active. The protocol logic next to it reads the current mode. It also uses a one-clock pulse that marks a line reset and a one-clock pulse that marks every change of mode. Decoding SWD packets and running the JTAG TAP controller are left to those neighbours.

All codes are received least significant bit first. From JTAG or SWD, the mode changes when a run of high samples is followed by a 16-bit switch code. From JTAG, a short high run followed by a 31-bit code puts the port to sleep. To wake the port, a high run of at least 8 is followed by a 128-bit alert pattern, four low samples and an activation code. When SWD is woken this way, it is held in reset until a full line reset has been seen.

Top module: `proto_sel_detect`

## Requirements
- R1: After reset the mode is JTAG, and both pulses are low. The mode encoding is 2'b00 JTAG, 2'b01 SWD, 2'b10 sleep, 2'b11 SWD held in reset.
- R2: A cycle with `bit_en` low is not a sample. The value on `bit_in` in that cycle does not affect the run count, the matchers or any output.
- R3: `line_rst` is high for one clock, in the clock after the sample, when a low sample ends a run of at least 50 high samples while the mode is not sleep. It never fires in sleep.
- R4: In JTAG or SWD, a run of at least 50 highs followed by 16'hE79E selects SWD, and followed by 16'hE73C selects JTAG. Bits arrive LSB first, and the low that ends the run is bit 0. A code that names the current mode changes nothing and gives no pulse.
- R5: In SWD, a run of at least 50 highs followed by 16'hE3BC enters sleep.
- R6: In JTAG, a run of at least 5 highs followed by the 31-bit code 31'h33BBBBBA enters sleep. After a run of only 4 highs, the same code has no effect.
- R7: In sleep, a run of at least 8 highs must come first. It is followed by the 128-bit alert 128'h19BC0EA2_E3DDAFE9_86852D95_6209F392 (LSB first), then 4 low samples, then an activation code. The 8-bit code 8'h1A gives SWD held in reset (2'b11). Twelve zero bits give JTAG, and so does the 8-bit code 8'h0A.
- R8: In SWD held in reset, a low sample that ends a run of at least 50 highs gives SWD. `line_rst` and `mode_chg` pulse in the same clock.
- R9: In sleep, a run of 8 highs in the middle of an alert abandons the partial match and starts the alert again.
- R10: A wrong bit in the alert, the four-low gap or the activation code returns the wake matcher to waiting for a high run. The mode is left unchanged.
- R11: `mode_chg` is high for exactly one clock, in the clock after the sample that changes the mode, and only when the mode really changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Marks the cycles that carry a pin sample |
| bit_in | input | 1 | Sampled mode/data pin value |
| mode | output | 2 | Current protocol mode (encoding in R1) |
| line_rst | output | 1 | One-clock line reset pulse |
| mode_chg | output | 1 | One-clock mode change pulse |

## Verification
Two functions can fire on the same sample: the line-reset detector and the exit from the SWD-held state. A single low sample that ends a run of 50 or more highs drives both. The bench wakes the port into SWD, sends a 50-high run and then one low. It then requires both pulses on that exact sample and neither one on the sample before. A second overlap occurs inside the alert, where the abort run and the bit-by-bit compare both act. The bench breaks off an alert with 8 highs partway through and requires that a fresh, complete alert still wakes the port.

// File: rtl/psel_pkg.sv
package psel_pkg;

  typedef enum logic [1:0] {
    LNK_JTAG     = 2'b00,
    LNK_SWD      = 2'b01,
    LNK_SLEEP    = 2'b10,
    LNK_SWD_HELD = 2'b11
  } link_mode_e;

  localparam int SW_CODE_LEN    = 16;
  localparam int SLEEP_J_LEN    = 31;
  localparam int ALERT_LEN      = 128;
  localparam int GAP_LEN        = 4;
  localparam int WAKE_SHORT_LEN = 8;
  localparam int WAKE_ZERO_LEN  = 12;

  localparam logic [SW_CODE_LEN-1:0] CODE_TO_SWD    = 16'hE79E;
  localparam logic [SW_CODE_LEN-1:0] CODE_TO_JTAG   = 16'hE73C;
  localparam logic [SW_CODE_LEN-1:0] CODE_SWD_SLEEP = 16'hE3BC;
  localparam logic [SLEEP_J_LEN-1:0] CODE_J_SLEEP   = 31'h33BBBBBA;

  localparam logic [ALERT_LEN-1:0] ALERT_PAT =
    128'h19BC0EA2_E3DDAFE9_86852D95_6209F392;

  localparam logic [WAKE_SHORT_LEN-1:0] WAKE_SWD_CODE  = 8'h1A;
  localparam logic [WAKE_SHORT_LEN-1:0] WAKE_JTAG_CODE = 8'h0A;

  // JTAG and SWD are the two modes in which the switch codes are decoded
  function automatic logic is_link_active(input link_mode_e m);
    return (m == LNK_JTAG) || (m == LNK_SWD);
  endfunction

  // Decode of a complete 16-bit window while in SWD mode
  function automatic logic swd_code_hit(input logic [SW_CODE_LEN-1:0] w);
    return (w == CODE_TO_SWD) || (w == CODE_TO_JTAG) || (w == CODE_SWD_SLEEP);
  endfunction

  function automatic link_mode_e swd_code_target(input logic [SW_CODE_LEN-1:0] w);
    link_mode_e r;
    if (w == CODE_TO_JTAG)        r = LNK_JTAG;
    else if (w == CODE_SWD_SLEEP) r = LNK_SLEEP;
    else                          r = LNK_SWD;
    return r;
  endfunction

  // Decode of a complete 16-bit window while in JTAG mode (long run only)
  function automatic logic jtag_code_hit(input logic [SW_CODE_LEN-1:0] w);
    return (w == CODE_TO_SWD) || (w == CODE_TO_JTAG);
  endfunction

endpackage

// File: rtl/psel_run_cnt.sv
module psel_run_cnt #(
  parameter int RUN_MAX = 50,
  localparam int RUN_W = $clog2(RUN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [RUN_W-1:0] run_q
);

  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);

  // Saturating count of consecutive high samples
  function automatic logic [RUN_W-1:0] run_step(input logic [RUN_W-1:0] r,
                                                 input logic b);
    logic [RUN_W-1:0] n;
    if (!b)               n = '0;
    else if (r == RUN_TOP) n = RUN_TOP;
    else                  n = r + 1'b1;
    return n;
  endfunction

  logic [RUN_W-1:0] run_d;

  always_comb begin
    run_d = run_q;
    if (bit_en) run_d = run_step(run_q, bit_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assert_run_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(run_q))
    else $error("run count moved without a sample");

endmodule

// File: rtl/psel_switch.sv
module psel_switch
  import psel_pkg::*;
#(
  parameter int LR_MIN  = 50,
  parameter int TLR_MIN = 5,
  parameter int RUN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic [RUN_W-1:0] run_q,
  input  link_mode_e       cur_mode,
  output logic             hit,
  output link_mode_e       hit_mode
);

  localparam int CNT_W = $clog2(SLEEP_J_LEN + 1);
  localparam int SH_W  = SLEEP_J_LEN;
  localparam logic [RUN_W-1:0] LONG_RUN = RUN_W'(LR_MIN);
  localparam logic [RUN_W-1:0] LONG_M1  = RUN_W'(LR_MIN - 1);
  localparam logic [RUN_W-1:0] TLR_M1   = RUN_W'(TLR_MIN - 1);
  localparam logic [CNT_W-1:0] CNT_SW   = CNT_W'(SW_CODE_LEN);
  localparam logic [CNT_W-1:0] CNT_J    = CNT_W'(SLEEP_J_LEN);

  typedef enum logic [1:0] {CS_IDLE, CS_ARM, CS_COLL} cstate_e;

  cstate_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_n;
  logic [SH_W-1:0]  sh_q, sh_d, nsh;
  logic             long_q, long_d;
  logic             active, in_jtag, reach;
  logic [SW_CODE_LEN-1:0] win;

  // Does the current high sample complete the run needed to arm?
  function automatic logic run_reached(input logic [RUN_W-1:0] r,
                                       input logic b,
                                       input logic [RUN_W-1:0] thr_m1);
    return b && (r >= thr_m1);
  endfunction

  assign active  = is_link_active(cur_mode);
  assign in_jtag = (cur_mode == LNK_JTAG);
  assign reach   = run_reached(run_q, bit_in, in_jtag ? TLR_M1 : LONG_M1);
  assign nsh     = {bit_in, sh_q[SH_W-1:1]};
  assign cnt_n   = cnt_q + 1'b1;
  assign win     = nsh[SH_W-1 -: SW_CODE_LEN];

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    long_d   = long_q;
    hit      = 1'b0;
    hit_mode = cur_mode;
    if (bit_en) begin
      if (!active) begin
        st_d = CS_IDLE;
      end else if (reach) begin
        st_d = CS_ARM;
      end else begin
        unique case (st_q)
          CS_IDLE: st_d = CS_IDLE;
          CS_ARM: begin
            st_d   = CS_COLL;
            cnt_d  = CNT_W'(1);
            sh_d   = nsh;
            long_d = (run_q >= LONG_RUN);
          end
          CS_COLL: begin
            cnt_d = cnt_n;
            sh_d  = nsh;
            if (cnt_n == CNT_SW) begin
              if (!in_jtag) begin
                st_d     = CS_IDLE;
                hit      = swd_code_hit(win);
                hit_mode = swd_code_target(win);
              end else if (long_q && jtag_code_hit(win)) begin
                st_d     = CS_IDLE;
                hit      = 1'b1;
                hit_mode = (win == CODE_TO_SWD) ? LNK_SWD : LNK_JTAG;
              end
            end else if (cnt_n == CNT_J) begin
              st_d = CS_IDLE;
              if (nsh == CODE_J_SLEEP) begin
                hit      = 1'b1;
                hit_mode = LNK_SLEEP;
              end
            end
          end
          default: st_d = CS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      long_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      long_q <= long_d;
    end
  end

  assert_hit_in_coll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (st_q == CS_COLL) && bit_en && active)
    else $error("switch code hit outside collection");

  assert_sleep_from_jtag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_mode == LNK_SLEEP && in_jtag) |-> (cnt_n == CNT_J))
    else $error("jtag sleep code taken at wrong length");

endmodule

// File: rtl/psel_wake.sv
module psel_wake
  import psel_pkg::*;
#(
  parameter int ABORT_MIN = 8,
  parameter int RUN_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic [RUN_W-1:0] run_q,
  input  logic             active,
  output logic             wake_swd,
  output logic             wake_jtag
);

  localparam int IDX_W = $clog2(ALERT_LEN);
  localparam int GAP_W = $clog2(GAP_LEN);
  localparam int ACT_W = $clog2(WAKE_ZERO_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(ALERT_LEN - 1);
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_LEN - 1);
  localparam logic [ACT_W-1:0] SHORT_LAST = ACT_W'(WAKE_SHORT_LEN - 1);
  localparam logic [ACT_W-1:0] ZERO_LAST  = ACT_W'(WAKE_ZERO_LEN - 1);
  localparam logic [ACT_W-1:0] SHORT_LEN  = ACT_W'(WAKE_SHORT_LEN);
  localparam logic [RUN_W-1:0] ABORT_M1   = RUN_W'(ABORT_MIN - 1);

  typedef enum logic [2:0] {WS_IDLE, WS_ARM, WS_ALERT, WS_GAP, WS_ACT} wstate_e;

  wstate_e          ws_q, ws_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [ACT_W-1:0] k_q, k_d;
  logic             ok_swd_q, ok_alt_q, ok_zero_q;
  logic             ok_swd_d, ok_alt_d, ok_zero_d;
  logic             abort_run, alert_ok, s_ok, a_ok, z_ok, in_short;

  assign abort_run = bit_in && (run_q >= ABORT_M1);
  assign alert_ok  = (bit_in == ALERT_PAT[idx_q]);
  assign in_short  = (k_q < SHORT_LEN);
  assign s_ok      = ok_swd_q && in_short && (bit_in == WAKE_SWD_CODE[k_q[2:0]]);
  assign a_ok      = ok_alt_q && in_short && (bit_in == WAKE_JTAG_CODE[k_q[2:0]]);
  assign z_ok      = ok_zero_q && !bit_in;

  always_comb begin
    ws_d      = ws_q;
    idx_d     = idx_q;
    gap_d     = gap_q;
    k_d       = k_q;
    ok_swd_d  = ok_swd_q;
    ok_alt_d  = ok_alt_q;
    ok_zero_d = ok_zero_q;
    wake_swd  = 1'b0;
    wake_jtag = 1'b0;
    if (bit_en) begin
      if (!active) begin
        ws_d = WS_IDLE;
      end else if (abort_run) begin
        ws_d = WS_ARM;
      end else begin
        unique case (ws_q)
          WS_IDLE: ws_d = WS_IDLE;
          WS_ARM: begin
            if (alert_ok && idx_q == '0) begin
              ws_d  = WS_ALERT;
              idx_d = IDX_W'(1);
            end else begin
              ws_d = WS_IDLE;
            end
          end
          WS_ALERT: begin
            if (!alert_ok)              ws_d = WS_IDLE;
            else if (idx_q == IDX_LAST) begin
              ws_d  = WS_GAP;
              gap_d = '0;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
          WS_GAP: begin
            if (bit_in)                 ws_d = WS_IDLE;
            else if (gap_q == GAP_LAST) begin
              ws_d      = WS_ACT;
              k_d       = '0;
              ok_swd_d  = 1'b1;
              ok_alt_d  = 1'b1;
              ok_zero_d = 1'b1;
            end else begin
              gap_d = gap_q + 1'b1;
            end
          end
          WS_ACT: begin
            if (k_q == SHORT_LAST && s_ok) begin
              wake_swd = 1'b1;
              ws_d     = WS_IDLE;
            end else if (k_q == SHORT_LAST && a_ok) begin
              wake_jtag = 1'b1;
              ws_d      = WS_IDLE;
            end else if (k_q == ZERO_LAST && z_ok) begin
              wake_jtag = 1'b1;
              ws_d      = WS_IDLE;
            end else if (!(s_ok || a_ok || z_ok)) begin
              ws_d = WS_IDLE;
            end else begin
              k_d       = k_q + 1'b1;
              ok_swd_d  = s_ok;
              ok_alt_d  = a_ok;
              ok_zero_d = z_ok;
            end
          end
          default: ws_d = WS_IDLE;
        endcase
      end
      if (ws_d != WS_ALERT && ws_d != WS_ARM) idx_d = '0;
      if (ws_d == WS_ARM)                      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q      <= WS_IDLE;
      idx_q     <= '0;
      gap_q     <= '0;
      k_q       <= '0;
      ok_swd_q  <= 1'b0;
      ok_alt_q  <= 1'b0;
      ok_zero_q <= 1'b0;
    end else begin
      ws_q      <= ws_d;
      idx_q     <= idx_d;
      gap_q     <= gap_d;
      k_q       <= k_d;
      ok_swd_q  <= ok_swd_d;
      ok_alt_q  <= ok_alt_d;
      ok_zero_q <= ok_zero_d;
    end
  end

  assert_wake_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_swd, wake_jtag}))
    else $error("both wake outcomes at once");

  assert_wake_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_swd || wake_jtag) |-> (active && bit_en && ws_q == WS_ACT))
    else $error("wake outcome outside activation phase");

  assert_abort_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && active && abort_run) |=> (ws_q == WS_ARM))
    else $error("high run did not restart alert matching");

endmodule

// File: rtl/proto_sel_detect.sv
module proto_sel_detect
  import psel_pkg::*;
#(
  parameter int LR_MIN    = 50,
  parameter int TLR_MIN   = 5,
  parameter int ABORT_MIN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  output logic [1:0] mode,
  output logic       line_rst,
  output logic       mode_chg
);

  localparam int RUN_W = $clog2(LR_MIN + 1);
  localparam logic [RUN_W-1:0] LONG_RUN = RUN_W'(LR_MIN);

  logic [RUN_W-1:0] run_q;
  link_mode_e       mode_q, mode_d, sw_mode;
  logic             sw_hit, wake_swd, wake_jtag;
  logic             long_end, lr_evt;
  logic             lr_q, chg_q;

  psel_run_cnt #(.RUN_MAX(LR_MIN)) u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .bit_in (bit_in),
    .run_q  (run_q)
  );

  psel_switch #(.LR_MIN(LR_MIN), .TLR_MIN(TLR_MIN), .RUN_W(RUN_W)) u_switch (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .run_q    (run_q),
    .cur_mode (mode_q),
    .hit      (sw_hit),
    .hit_mode (sw_mode)
  );

  psel_wake #(.ABORT_MIN(ABORT_MIN), .RUN_W(RUN_W)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .run_q     (run_q),
    .active    (mode_q == LNK_SLEEP),
    .wake_swd  (wake_swd),
    .wake_jtag (wake_jtag)
  );

  // Low sample closing a long high run
  assign long_end = bit_en && !bit_in && (run_q >= LONG_RUN);
  assign lr_evt   = long_end && (mode_q != LNK_SLEEP);

  always_comb begin
    mode_d = mode_q;
    if (bit_en) begin
      unique case (mode_q)
        LNK_SLEEP: begin
          if (wake_swd)       mode_d = LNK_SWD_HELD;
          else if (wake_jtag) mode_d = LNK_JTAG;
        end
        LNK_SWD_HELD: if (long_end) mode_d = LNK_SWD;
        default:      if (sw_hit)   mode_d = sw_mode;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LNK_JTAG;
      lr_q   <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lr_q   <= lr_evt;
      chg_q  <= (mode_d != mode_q);
    end
  end

  assign mode     = mode_q;
  assign line_rst = lr_q;
  assign mode_chg = chg_q;

  assert_chg_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !mode_chg)
    else $error("mode change pulse wider than one clock");

  assert_chg_sampled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> $past(bit_en))
    else $error("mode change without a sample");

  assert_lr_awake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_rst |-> (mode_q != LNK_SLEEP))
    else $error("line reset reported in sleep");

  assert_held_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == LNK_SWD_HELD && $past(mode_q) != LNK_SWD_HELD) |->
      ($past(mode_q) == LNK_SLEEP))
    else $error("held SWD entered from an awake mode");

  assert_held_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == LNK_SWD_HELD && mode_q != LNK_SWD_HELD) |-> line_rst)
    else $error("held SWD left without a line reset");

endmodule

// File: tb/tb_proto_sel_detect.sv
module tb_proto_sel_detect;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic [1:0] mode;
  logic       line_rst, mode_chg;

  int checks = 0;
  int errors = 0;
  int lr_cnt = 0;
  int chg_cnt = 0;
  logic last_lr = 1'b0;
  logic last_chg = 1'b0;
  bit done = 1'b0;

  localparam logic [1:0] M_JTAG = 2'b00, M_SWD = 2'b01, M_SLEEP = 2'b10, M_HELD = 2'b11;

  always #10 clk = ~clk;

  proto_sel_detect dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .mode(mode), .line_rst(line_rst), .mode_chg(mode_chg)
  );

  function automatic logic [127:0] alert_vec();
    logic [7:0] b [16] = '{8'h92, 8'hF3, 8'h09, 8'h62, 8'h95, 8'h2D, 8'h85, 8'h86,
                           8'hE9, 8'hAF, 8'hDD, 8'hE3, 8'hA2, 8'h0E, 8'hBC, 8'h19};
    logic [127:0] v = '0;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = b[i];
    return v;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic observe();
    @(posedge clk);
    @(negedge clk);
    last_lr  = line_rst;
    last_chg = mode_chg;
    if (line_rst) lr_cnt++;
    if (mode_chg) chg_cnt++;
  endtask

  task automatic send(input logic b, input bit gapped);
    bit_in = b;
    bit_en = 1'b1;
    observe();
    bit_en = 1'b0;
    if (gapped) begin
      bit_in = ~b;
      observe();
    end
  endtask

  task automatic run(input int n, input logic v, input bit gapped);
    for (int i = 0; i < n; i++) send(v, gapped);
  endtask

  task automatic bits(input logic [127:0] v, input int n, input bit gapped);
    for (int i = 0; i < n; i++) send(v[i], gapped);
  endtask

  task automatic clr();
    lr_cnt = 0;
    chg_cnt = 0;
  endtask

  task automatic jtag_to_sleep();
    send(1'b0, 1'b0);
    run(6, 1'b1, 1'b0);
    bits(128'h33BBBBBA, 31, 1'b0);
  endtask

  task automatic t_reset();
    check("R1", "mode", mode, M_JTAG);
    check("R1", "line_rst", line_rst, 0);
    check("R1", "mode_chg", mode_chg, 0);
  endtask

  task automatic t_jtag_to_swd_gapped();
    clr();
    run(55, 1'b1, 1'b1);
    bits(128'hE79E, 15, 1'b1);
    check("R4", "mode before last code bit", mode, M_JTAG);
    check("R3", "line reset in JTAG", lr_cnt, 1);
    send(1'b1, 1'b1);
    check("R4", "mode after E79E", mode, M_SWD);
    check("R11", "chg count", chg_cnt, 1);
    clr();
    bit_en = 1'b0;
    bit_in = 1'b1;
    repeat (60) @(negedge clk);
    send(1'b0, 1'b0);
    check("R2", "no line reset from unsampled highs", lr_cnt, 0);
    check("R2", "mode held", mode, M_SWD);
  endtask

  task automatic t_swd_line_reset();
    clr();
    run(60, 1'b1, 1'b0);
    check("R3", "no pulse during run", lr_cnt, 0);
    send(1'b0, 1'b0);
    check("R3", "pulse on closing low", last_lr, 1);
    send(1'b0, 1'b0);
    check("R3", "single pulse", lr_cnt, 1);
    check("R11", "no mode change", chg_cnt, 0);
  endtask

  task automatic t_swd_same_code();
    clr();
    run(50, 1'b1, 1'b0);
    bits(128'hE79E, 16, 1'b0);
    check("R4", "mode stays SWD", mode, M_SWD);
    check("R4", "no change pulse", chg_cnt, 0);
  endtask

  task automatic t_swd_to_jtag();
    clr();
    run(52, 1'b1, 1'b0);
    bits(128'hE73C, 16, 1'b0);
    check("R4", "mode after E73C", mode, M_JTAG);
    check("R11", "change pulse on last bit", last_chg, 1);
  endtask

  task automatic t_jtag_sleep();
    clr();
    send(1'b0, 1'b0);
    run(4, 1'b1, 1'b0);
    bits(128'h33BBBBBA, 31, 1'b0);
    check("R6", "short run ignored", mode, M_JTAG);
    send(1'b0, 1'b0);
    run(6, 1'b1, 1'b0);
    bits(128'h33BBBBBA, 30, 1'b0);
    check("R6", "mode before last bit", mode, M_JTAG);
    send(1'b0, 1'b0);
    check("R6", "sleep entered", mode, M_SLEEP);
    check("R11", "one change", chg_cnt, 1);
  endtask

  task automatic t_sleep_no_lr();
    clr();
    run(60, 1'b1, 1'b0);
    send(1'b0, 1'b0);
    send(1'b0, 1'b0);
    check("R3", "no line reset in sleep", lr_cnt, 0);
    check("R3", "still asleep", mode, M_SLEEP);
  endtask

  task automatic wake_prefix();
    run(8, 1'b1, 1'b0);
    bits(alert_vec(), 128, 1'b0);
    run(4, 1'b0, 1'b0);
  endtask

  task automatic t_wake_swd_and_release();
    clr();
    wake_prefix();
    bits(128'h1A, 8, 1'b0);
    check("R7", "held SWD after 1A", mode, M_HELD);
    check("R7", "one change", chg_cnt, 1);
    clr();
    run(50, 1'b1, 1'b0);
    check("R8", "still held after highs", mode, M_HELD);
    check("R8", "no pulses yet", lr_cnt + chg_cnt, 0);
    send(1'b0, 1'b0);
    check("R8", "line reset on release", last_lr, 1);
    check("R8", "change on release", last_chg, 1);
    check("R8", "mode SWD", mode, M_SWD);
  endtask

  task automatic t_swd_to_sleep();
    clr();
    run(50, 1'b1, 1'b0);
    bits(128'hE3BC, 16, 1'b0);
    check("R5", "sleep from SWD", mode, M_SLEEP);
    check("R11", "one change", chg_cnt, 1);
  endtask

  task automatic t_wake_jtag_zeros();
    clr();
    send(1'b0, 1'b0);
    wake_prefix();
    run(11, 1'b0, 1'b0);
    check("R7", "asleep before 12th zero", mode, M_SLEEP);
    send(1'b0, 1'b0);
    check("R7", "JTAG after 12 zeros", mode, M_JTAG);
  endtask

  task automatic t_wake_jtag_short();
    jtag_to_sleep();
    check("R6", "asleep again", mode, M_SLEEP);
    clr();
    wake_prefix();
    bits(128'h0A, 8, 1'b0);
    check("R7", "JTAG after 0A", mode, M_JTAG);
    check("R7", "one change", chg_cnt, 1);
  endtask

  task automatic t_bad_alert();
    jtag_to_sleep();
    clr();
    run(8, 1'b1, 1'b0);
    bits(alert_vec() ^ (128'd1 << 40), 128, 1'b0);
    run(4, 1'b0, 1'b0);
    bits(128'h1A, 8, 1'b0);
    check("R10", "corrupt alert keeps sleep", mode, M_SLEEP);
    check("R10", "no change pulse", chg_cnt, 0);
    run(8, 1'b1, 1'b0);
    bits(alert_vec(), 128, 1'b0);
    bits(128'h4, 4, 1'b0);
    bits(128'h1A, 8, 1'b0);
    check("R10", "bad gap keeps sleep", mode, M_SLEEP);
    check("R10", "no change pulse after gap", chg_cnt, 0);
  endtask

  task automatic t_abort_restart();
    clr();
    run(8, 1'b1, 1'b0);
    bits(alert_vec(), 60, 1'b0);
    run(8, 1'b1, 1'b0);
    wake_prefix();
    bits(128'h1A, 8, 1'b0);
    check("R9", "fresh alert after abort wakes", mode, M_HELD);
    check("R9", "one change", chg_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_jtag_to_swd_gapped();
    t_swd_line_reset();
    t_swd_same_code();
    t_swd_to_jtag();
    t_jtag_sleep();
    t_sleep_no_lr();
    t_wake_swd_and_release();
    t_swd_to_sleep();
    t_wake_jtag_zeros();
    t_wake_jtag_short();
    t_bad_alert();
    t_abort_restart();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule